// File: doc/BRIEF.md
# Double-Buffered Serial Transmit Path

This block is the transmit half of a synchronous serial I/O port. Software hands it bytes through a write strobe. Each byte is sent as an 8-bit frame on a serial data line, least significant bit first. An optional holding buffer sits in front of the shift register, and an optional four-entry FIFO can feed that holding buffer. With both in place, frames follow one another with no gap, provided software keeps ahead of the line.

The serial clock comes from one of two sources. The block can make its own clock by dividing the system clock by four; in that case the clock runs only while a frame is in flight. It can instead follow an external serial clock, whose falling edges are synchronised into the system clock domain. In external-clock mode the far end sets the pace, so a byte that is missing when the next frame should start is reported as an underrun.

The block reports back through four outputs: a one-cycle transmit interrupt, a flag that shows the holding buffer is free, and two sticky error flags for underrun and FIFO overflow. A status-read strobe clears both error flags. The three configuration inputs must only change while the block is idle or held in reset.

Top module: `sio_tx_path`

## Requirements
- R1: After reset, `sdo` and `sclk_out` are 1, `buf_empty` is 1, and `tx_irq`, `underrun_flag` and `fifo_overflow` are 0.
- R2: A frame is 8 bits, sent bit 0 first. In internal-clock mode, `sclk_out` drops to 0 in the cycle the shift register loads. It then runs with a period of 4 system clocks (2 low, 2 high). `sdo` changes only when `sclk_out` falls, so it is stable at every rising edge.
- R3: With `cfg_dbuf_en`=0, a write loads the shift register directly, but only if the shift register is idle. A write while a frame is in flight is ignored. `tx_irq` pulses when the frame finishes, and does not pulse at the load.
- R4: With `cfg_dbuf_en`=1, a write fills the holding buffer and clears `buf_empty` in the next cycle. Moving the holding buffer into the shift register pulses `tx_irq` and sets `buf_empty` in the same cycle, unless the FIFO refills the buffer at once.
- R5: If the holding buffer is full when a frame ends, the next frame starts at once. In internal-clock mode the gap between the last rising edge of one frame and the first rising edge of the next is one normal clock period.
- R6: In internal-clock mode the serial clock stops, and stays high, once a frame ends with no data waiting. No underrun is ever flagged in this mode.
- R7: With `cfg_dbuf_en`=1 and `cfg_fifo_en`=1, writes go into a 4-entry FIFO. The FIFO head moves into the holding buffer whenever that buffer is empty. Bytes are sent in the order written.
- R8: A write into a full FIFO is dropped and sets the sticky `fifo_overflow` flag.
- R9: In external-clock mode, each synchronised falling edge of `ext_sclk` advances the shift register. An idle shift register with a full holding buffer loads that buffer on a falling edge.
- R10: In external-clock mode with double buffering on and the FIFO off, consider the first falling edge after a frame ends with nothing to reload. If the holding buffer is still empty at that edge, `underrun_flag` is set and stays set. The frame end alone does not set the flag, and with the FIFO on the flag is never set.
- R11: A one-cycle `stat_rd` clears `underrun_flag` and `fifo_overflow` in the next cycle.
- R12: `tx_irq` is never high for two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_dbuf_en | input | 1 | 1 = route writes through the holding buffer |
| cfg_fifo_en | input | 1 | 1 = route writes through the FIFO (takes effect only with cfg_dbuf_en) |
| cfg_ext_clk | input | 1 | 1 = follow ext_sclk, 0 = generate the serial clock |
| wr_en | input | 1 | Write strobe for transmit data |
| wr_data | input | 8 | Transmit byte |
| stat_rd | input | 1 | Status read strobe; clears the error flags |
| ext_sclk | input | 1 | External serial clock, asynchronous |
| sclk_out | output | 1 | Generated serial clock; idles high, held high in external mode |
| sdo | output | 1 | Serial data out; idles high |
| tx_irq | output | 1 | One-cycle transmit interrupt |
| buf_empty | output | 1 | Holding buffer is free |
| underrun_flag | output | 1 | Sticky underrun error |
| fifo_overflow | output | 1 | Sticky FIFO overflow error |

## Verification
The hardest case to reach from the ports is the external-clock underrun. It needs double buffering on, the FIFO off, a frame that ends with an empty holding buffer, and then one more external falling edge before any write. The bench drives `ext_sclk` edge by edge itself. It writes the second byte only after the first falling edge has moved the first byte out of the holding buffer, so the two bytes do not overwrite each other. It then adds one falling edge to end the second frame and checks that the flag is still clear. A further falling edge must set it. Later edges check that the flag holds, and a status read checks that it clears and is not set again.

// File: rtl/sio_tx_pkg.sv
package sio_tx_pkg;

    // Effective configuration after gating the FIFO by the buffer enable
    typedef struct packed {
        logic dbuf_en;
        logic fifo_en;
        logic ext_clk;
    } tx_cfg_t;

    // Source feeding the shift register on a load
    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_HOLD = 2'd1,
        SRC_CPU  = 2'd2
    } load_src_e;

    // Per-cycle control decisions
    typedef struct packed {
        load_src_e src;
        logic      hold_wr;
        logic      push;
        logic      pop;
        logic      ovf;
        logic      irq;
        logic      urun;
        logic      stall;
    } tx_ctl_t;

    function automatic tx_cfg_t make_cfg(input logic dbuf, input logic fifo, input logic ext);
        tx_cfg_t c;
        c.dbuf_en = dbuf;
        c.fifo_en = dbuf & fifo;
        c.ext_clk = ext;
        return c;
    endfunction

    // An idle, starved shifter sees a far-end frame edge
    function automatic logic urun_event(input tx_cfg_t c, input logic tick, input logic busy,
                                        input logic hold_full, input logic primed);
        return c.ext_clk & c.dbuf_en & ~c.fifo_en & tick & ~busy & ~hold_full & primed;
    endfunction

endpackage

// File: rtl/sio_tx_fifo.sv
module sio_tx_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic         pop,
    input  logic [W-1:0] din,
    output logic [W-1:0] head,
    output logic         empty,
    output logic         full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] LAST_PTR = AW'(DEPTH - 1);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp_q, rp_q;
    logic [CW-1:0] cnt_q;
    logic          do_push, do_pop;

    assign empty   = (cnt_q == '0);
    assign full    = (cnt_q == FULL_CNT);
    assign do_push = push & ~full;
    assign do_pop  = pop & ~empty;
    assign head    = mem[rp_q];

    always_ff @(posedge clk) begin
        if (do_push) mem[wp_q] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (do_push) wp_q <= (wp_q == LAST_PTR) ? '0 : wp_q + AW'(1);
            if (do_pop)  rp_q <= (rp_q == LAST_PTR) ? '0 : rp_q + AW'(1);
            case ({do_push, do_pop})
                2'b10:   cnt_q <= cnt_q + CW'(1);
                2'b01:   cnt_q <= cnt_q - CW'(1);
                default: cnt_q <= cnt_q;
            endcase
        end
    end
endmodule

// File: rtl/sio_tx_clkgen.sv
module sio_tx_clkgen #(
    parameter int DIV  = 4,
    parameter int SYNC = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic ext_mode,
    input  logic run,
    input  logic ext_sclk,
    output logic tick,
    output logic sclk_out
);
    localparam int DW = (DIV > 2) ? $clog2(DIV) : 1;
    localparam logic [DW-1:0] DIV_LAST = DW'(DIV - 1);
    localparam logic [DW-1:0] DIV_HALF = DW'(DIV / 2);

    logic [DW-1:0]   div_q;
    logic [SYNC-1:0] sync_q;
    logic            last_q;
    logic            tick_int, tick_ext;

    // Internal divider runs only while a frame is active
    always_ff @(posedge clk) begin
        if (rst)                    div_q <= '0;
        else if (run && !ext_mode)  div_q <= (div_q == DIV_LAST) ? '0 : div_q + DW'(1);
        else                        div_q <= '0;
    end

    // External clock: synchroniser chain plus edge history, idle high
    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '1;
            last_q <= 1'b1;
        end else begin
            sync_q <= {sync_q[SYNC-2:0], ext_sclk};
            last_q <= sync_q[SYNC-1];
        end
    end

    assign tick_int = run & ~ext_mode & (div_q == DIV_LAST);
    assign tick_ext = ext_mode & last_q & ~sync_q[SYNC-1];
    assign tick     = tick_int | tick_ext;
    assign sclk_out = (ext_mode | ~run) ? 1'b1 : (div_q >= DIV_HALF);
endmodule

// File: rtl/sio_tx_shifter.sv
module sio_tx_shifter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic         load,
    input  logic [W-1:0] ld_data,
    output logic         active,
    output logic         sdo,
    output logic         done
);
    localparam int CW = $clog2(W);
    localparam logic [CW-1:0] LAST_BIT = CW'(W - 1);

    logic [W-1:0]  sr_q;
    logic [CW-1:0] cnt_q;
    logic          act_q;

    assign done   = tick & act_q & (cnt_q == LAST_BIT);
    assign active = act_q;
    assign sdo    = act_q ? sr_q[0] : 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            sr_q  <= '1;
            cnt_q <= '0;
            act_q <= 1'b0;
        end else if (load) begin
            sr_q  <= ld_data;
            cnt_q <= '0;
            act_q <= 1'b1;
        end else if (tick && act_q) begin
            if (cnt_q == LAST_BIT) begin
                act_q <= 1'b0;
            end else begin
                sr_q  <= {1'b1, sr_q[W-1:1]};
                cnt_q <= cnt_q + CW'(1);
            end
        end
    end
endmodule

// File: rtl/sio_tx_path.sv
module sio_tx_path #(
    parameter int DATA_W     = 8,
    parameter int FIFO_DEPTH = 4,
    parameter int CLK_DIV    = 4,
    parameter int SYNC_STAGE = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_dbuf_en,
    input  logic              cfg_fifo_en,
    input  logic              cfg_ext_clk,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              stat_rd,
    input  logic              ext_sclk,
    output logic              sclk_out,
    output logic              sdo,
    output logic              tx_irq,
    output logic              buf_empty,
    output logic              underrun_flag,
    output logic              fifo_overflow
);
    import sio_tx_pkg::*;

    tx_cfg_t           cfg;
    tx_ctl_t           ctl;
    logic              tick, active, done, load;
    logic [DATA_W-1:0] ld_data;
    logic [DATA_W-1:0] hold_q;
    logic              hold_full_q;
    logic              primed_q;
    logic [DATA_W-1:0] fifo_head;
    logic              fifo_empty, fifo_full;
    logic              irq_q, urun_q, ovf_q;

    assign cfg = make_cfg(cfg_dbuf_en, cfg_fifo_en, cfg_ext_clk);

    // Decide this cycle's moves
    always_comb begin
        ctl         = '0;
        ctl.src     = SRC_NONE;
        ctl.hold_wr = cfg.dbuf_en & ~cfg.fifo_en & wr_en;
        ctl.push    = cfg.fifo_en & wr_en & ~fifo_full;
        ctl.ovf     = cfg.fifo_en & wr_en & fifo_full;
        if (cfg.dbuf_en && hold_full_q && (done || (!active && (!cfg.ext_clk || tick))))
            ctl.src = SRC_HOLD;
        else if (!cfg.dbuf_en && wr_en && !active)
            ctl.src = SRC_CPU;
        ctl.pop   = cfg.fifo_en & ~fifo_empty & (~hold_full_q | (ctl.src == SRC_HOLD));
        ctl.irq   = cfg.dbuf_en ? (ctl.src == SRC_HOLD) : done;
        ctl.urun  = urun_event(cfg, tick, active, hold_full_q, primed_q);
        ctl.stall = cfg.dbuf_en & done & (ctl.src != SRC_HOLD);
    end

    always_comb begin
        unique case (ctl.src)
            SRC_HOLD: ld_data = hold_q;
            SRC_CPU:  ld_data = wr_data;
            default:  ld_data = '1;
        endcase
    end

    assign load = (ctl.src != SRC_NONE);

    sio_tx_clkgen #(.DIV(CLK_DIV), .SYNC(SYNC_STAGE)) u_clk (
        .clk      (clk),
        .rst      (rst),
        .ext_mode (cfg.ext_clk),
        .run      (active),
        .ext_sclk (ext_sclk),
        .tick     (tick),
        .sclk_out (sclk_out)
    );

    sio_tx_shifter #(.W(DATA_W)) u_shift (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick),
        .load    (load),
        .ld_data (ld_data),
        .active  (active),
        .sdo     (sdo),
        .done    (done)
    );

    generate
        if (FIFO_DEPTH > 0) begin : g_fifo
            sio_tx_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
                .clk   (clk),
                .rst   (rst),
                .push  (ctl.push),
                .pop   (ctl.pop),
                .din   (wr_data),
                .head  (fifo_head),
                .empty (fifo_empty),
                .full  (fifo_full)
            );
        end else begin : g_nofifo
            assign fifo_head  = '1;
            assign fifo_empty = 1'b1;
            assign fifo_full  = 1'b1;
        end
    endgenerate

    // Holding buffer: CPU write beats FIFO refill, which beats drain
    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q      <= '0;
            hold_full_q <= 1'b0;
        end else if (ctl.hold_wr) begin
            hold_q      <= wr_data;
            hold_full_q <= 1'b1;
        end else if (ctl.pop) begin
            hold_q      <= fifo_head;
            hold_full_q <= 1'b1;
        end else if (ctl.src == SRC_HOLD) begin
            hold_full_q <= 1'b0;
        end
    end

    // Armed after a starved frame end, disarmed by a load or a flagged underrun
    always_ff @(posedge clk) begin
        if (rst)                     primed_q <= 1'b0;
        else if (ctl.urun || load)   primed_q <= 1'b0;
        else if (ctl.stall)          primed_q <= 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_q  <= 1'b0;
            urun_q <= 1'b0;
            ovf_q  <= 1'b0;
        end else begin
            irq_q <= ctl.irq;
            if (ctl.urun)     urun_q <= 1'b1;
            else if (stat_rd) urun_q <= 1'b0;
            if (ctl.ovf)      ovf_q  <= 1'b1;
            else if (stat_rd) ovf_q  <= 1'b0;
        end
    end

    assign tx_irq        = irq_q;
    assign buf_empty     = ~hold_full_q;
    assign underrun_flag = urun_q;
    assign fifo_overflow = ovf_q;
endmodule

// File: rtl/sio_tx_path_chk.sv
module sio_tx_path_chk (
    input logic clk,
    input logic rst,
    input logic cfg_dbuf_en,
    input logic cfg_fifo_en,
    input logic cfg_ext_clk,
    input logic wr_en,
    input logic stat_rd,
    input logic tx_irq,
    input logic buf_empty,
    input logic underrun_flag,
    input logic fifo_overflow
);
    // R12: interrupt is a single-cycle pulse
    a_r12_irq_single: assert property (@(posedge clk) disable iff (rst)
        tx_irq |=> !tx_irq);

    // R6: internal clock mode never raises underrun
    a_r6_no_urun_internal: assert property (@(posedge clk) disable iff (rst)
        (!cfg_ext_clk && !underrun_flag) |=> !underrun_flag);

    // R10: with the FIFO feeding the buffer no underrun is raised
    a_r10_no_urun_fifo: assert property (@(posedge clk) disable iff (rst)
        (cfg_dbuf_en && cfg_fifo_en && !underrun_flag) |=> !underrun_flag);

    // R10: underrun is sticky until a status read
    a_r10_urun_sticky: assert property (@(posedge clk) disable iff (rst)
        (underrun_flag && !stat_rd) |=> underrun_flag);

    // R8: overflow is sticky until a status read
    a_r8_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
        (fifo_overflow && !stat_rd) |=> fifo_overflow);

    // R11: a status read in internal mode leaves underrun clear
    a_r11_read_clears: assert property (@(posedge clk) disable iff (rst)
        (stat_rd && !cfg_ext_clk) |=> !underrun_flag);

    // R4: a write to the holding buffer clears the empty flag
    a_r4_write_fills: assert property (@(posedge clk) disable iff (rst)
        (wr_en && cfg_dbuf_en && !cfg_fifo_en) |=> !buf_empty);

    // R4: the interrupt of a move comes with an empty buffer unless rewritten
    a_r4_move_empties: assert property (@(posedge clk) disable iff (rst)
        (tx_irq && cfg_dbuf_en && !cfg_fifo_en) |-> (buf_empty || $past(wr_en)));
endmodule

bind sio_tx_path sio_tx_path_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .cfg_dbuf_en   (cfg_dbuf_en),
    .cfg_fifo_en   (cfg_fifo_en),
    .cfg_ext_clk   (cfg_ext_clk),
    .wr_en         (wr_en),
    .stat_rd       (stat_rd),
    .tx_irq        (tx_irq),
    .buf_empty     (buf_empty),
    .underrun_flag (underrun_flag),
    .fifo_overflow (fifo_overflow)
);

// File: tb/sio_tx_path_test.sv
`timescale 1ns/1ps
module sio_tx_path_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_dbuf_en = 1'b0, cfg_fifo_en = 1'b0, cfg_ext_clk = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       stat_rd = 1'b0;
    logic       ext_sclk = 1'b1;
    logic       sclk, sdo, tx_irq, buf_empty, underrun_flag, fifo_overflow;

    sio_tx_path uut (
        .clk(clk), .rst(rst),
        .cfg_dbuf_en(cfg_dbuf_en), .cfg_fifo_en(cfg_fifo_en), .cfg_ext_clk(cfg_ext_clk),
        .wr_en(wr_en), .wr_data(wr_data), .stat_rd(stat_rd), .ext_sclk(ext_sclk),
        .sclk_out(sclk), .sdo(sdo), .tx_irq(tx_irq), .buf_empty(buf_empty),
        .underrun_flag(underrun_flag), .fifo_overflow(fifo_overflow)
    );

    always #2.5 clk = ~clk;

    int         n_chk = 0, n_fail = 0;
    int         irq_cnt = 0, irq_double = 0;
    logic       irq_prev = 1'b0;
    logic       mon_on = 1'b0;
    logic [7:0] rx [16];
    int         rx_n = 0, nbits = 0;
    logic [7:0] acc = 8'h00;
    longint     bit_t [64];

    function automatic void take_bit(input logic b);
        if (nbits < 64) bit_t[nbits] = $time;
        acc = {b, acc[7:1]};
        nbits++;
        if ((nbits % 8) == 0 && rx_n < 16) begin
            rx[rx_n] = acc;
            rx_n++;
        end
    endfunction

    // Receiver model: sample data on each rising generated clock
    always @(posedge sclk) if (mon_on && !rst) take_bit(sdo);

    always @(negedge clk) begin
        if (!rst && tx_irq) irq_cnt++;
        if (!rst && tx_irq && irq_prev) irq_double++;
        irq_prev = tx_irq;
    end

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic do_reset(input logic d, input logic f, input logic e);
        @(negedge clk);
        rst = 1'b1; mon_on = 1'b0;
        cfg_dbuf_en = d; cfg_fifo_en = f; cfg_ext_clk = e;
        wr_en = 1'b0; stat_rd = 1'b0; ext_sclk = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        rx_n = 0; nbits = 0; acc = 8'h00; irq_cnt = 0;
        mon_on = 1'b1;
    endtask

    task automatic wr(input logic [7:0] b);
        @(negedge clk);
        wr_en = 1'b1; wr_data = b;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic status_read();
        @(negedge clk);
        stat_rd = 1'b1;
        @(negedge clk);
        stat_rd = 1'b0;
    endtask

    task automatic ext_pulse(input int n, input logic cap);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            ext_sclk = 1'b0;
            repeat (6) @(negedge clk);
            if (cap) take_bit(sdo);
            ext_sclk = 1'b1;
            repeat (6) @(negedge clk);
        end
    endtask

    task automatic t_reset_state();
        do_reset(1'b1, 1'b0, 1'b0);
        chk("R1", "sdo", sdo, 1);
        chk("R1", "sclk_out", sclk, 1);
        chk("R1", "buf_empty", buf_empty, 1);
        chk("R1", "tx_irq", tx_irq, 0);
        chk("R1", "underrun_flag", underrun_flag, 0);
        chk("R1", "fifo_overflow", fifo_overflow, 0);
    endtask

    task automatic t_direct();
        do_reset(1'b0, 1'b0, 1'b0);
        wr(8'hC5);
        chk("R2", "sclk low at load", sclk, 0);
        chk("R2", "first bit on line", sdo, 1);
        chk("R3", "no irq at load", irq_cnt, 0);
        repeat (4) @(negedge clk);
        wr(8'h0F);  // shifter busy: must be ignored
        repeat (45) @(negedge clk);
        chk("R3", "frames sent", rx_n, 1);
        chk("R2", "byte lsb first", rx[0], 8'hC5);
        chk("R2", "clock period", bit_t[1] - bit_t[0], 20);
        chk("R3", "irq at frame end", irq_cnt, 1);
        chk("R3", "busy write ignored bits", nbits, 8);
    endtask

    task automatic t_dbuf();
        do_reset(1'b1, 1'b0, 1'b0);
        wr(8'h96);
        chk("R4", "buf_empty after write", buf_empty, 0);
        @(negedge clk);
        chk("R4", "irq on move", tx_irq, 1);
        chk("R4", "buf_empty on move", buf_empty, 1);
        @(negedge clk);
        chk("R12", "irq single cycle", tx_irq, 0);
        wr(8'h5A);
        chk("R4", "buf_empty after second write", buf_empty, 0);
        repeat (90) @(negedge clk);
        chk("R5", "frames sent", rx_n, 2);
        chk("R5", "first byte", rx[0], 8'h96);
        chk("R5", "second byte", rx[1], 8'h5A);
        chk("R5", "no gap between frames", bit_t[8] - bit_t[7], 20);
        chk("R4", "irq per move", irq_cnt, 2);
        chk("R4", "buf_empty at end", buf_empty, 1);
        chk("R6", "clock parked high", sclk, 1);
        begin
            int seen = nbits;
            repeat (30) @(negedge clk);
            chk("R6", "clock stays stopped", nbits, seen);
        end
        chk("R6", "no underrun internal", underrun_flag, 0);
    endtask

    task automatic t_fifo();
        logic [7:0] exp [6] = '{8'h11, 8'h22, 8'h33, 8'h44, 8'h55, 8'h66};
        do_reset(1'b1, 1'b1, 1'b0);
        for (int i = 0; i < 6; i++) wr(exp[i]);
        chk("R8", "no overflow before full write", fifo_overflow, 0);
        wr(8'h77);
        chk("R8", "overflow on full write", fifo_overflow, 1);
        repeat (260) @(negedge clk);
        chk("R7", "bytes sent", rx_n, 6);
        for (int i = 0; i < 6; i++) chk("R7", "fifo order", rx[i], exp[i]);
        chk("R7", "irq count", irq_cnt, 6);
        chk("R8", "overflow sticky", fifo_overflow, 1);
        status_read();
        chk("R11", "overflow cleared by read", fifo_overflow, 0);
    endtask

    task automatic t_ext_underrun();
        do_reset(1'b1, 1'b0, 1'b1);
        wr(8'hB3);
        ext_pulse(1, 1'b1);
        chk("R9", "buf_empty after edge load", buf_empty, 1);
        wr(8'h4E);
        ext_pulse(15, 1'b1);
        chk("R9", "bytes sent", rx_n, 2);
        chk("R9", "first byte", rx[0], 8'hB3);
        chk("R9", "second byte", rx[1], 8'h4E);
        chk("R9", "sclk_out held high", sclk, 1);
        chk("R4", "irq per move", irq_cnt, 2);
        ext_pulse(1, 1'b0);
        chk("R10", "no underrun at frame end", underrun_flag, 0);
        ext_pulse(1, 1'b0);
        chk("R10", "underrun on starved edge", underrun_flag, 1);
        ext_pulse(1, 1'b0);
        chk("R10", "underrun sticky", underrun_flag, 1);
        status_read();
        chk("R11", "underrun cleared by read", underrun_flag, 0);
        ext_pulse(1, 1'b0);
        chk("R10", "single report per gap", underrun_flag, 0);
    endtask

    task automatic t_ext_fifo();
        do_reset(1'b1, 1'b1, 1'b1);
        wr(8'hA1); wr(8'h2B); wr(8'hC7);
        ext_pulse(24, 1'b1);
        ext_pulse(3, 1'b0);
        chk("R9", "ext fifo bytes", rx_n, 3);
        chk("R7", "ext fifo byte 0", rx[0], 8'hA1);
        chk("R7", "ext fifo byte 1", rx[1], 8'h2B);
        chk("R7", "ext fifo byte 2", rx[2], 8'hC7);
        chk("R10", "no underrun with fifo", underrun_flag, 0);
        chk("R12", "no back-to-back irq", irq_double, 0);
    endtask

    function automatic void summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        t_reset_state();
        t_direct();
        t_dbuf();
        t_fifo();
        t_ext_underrun();
        t_ext_fifo();
        summary();
        $finish;
    end
endmodule